// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Controller

This block gathers the interrupt requests of a small 8-bit processor core. Three hardware lines are watched: a timer overflow, a port input change request and an external pin. All three are active low, and each one fires on its falling edge after a synchroniser. Each source owns a flag bit and a mask bit. The core reaches both registers over a one-word register port. A status read gives only the flags that are unmasked.

A global enable bit is set by an enable strobe or by a return-from-interrupt strobe, and it is cleared by a disable strobe. When the global enable is on and any unmasked flag is set, the block asks the core to redirect its next fetch to the hardware vector. A software-trap strobe asks for a redirect to a separate trap vector instead. Either redirect clears the global enable, so a service routine cannot be nested.

While the core sleeps, an unmasked port-change flag raises a wake output. The core resumes in line if the global enable is off, or it takes the hardware vector if the global enable is on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the flag register, the mask register and the global enable are all 0, and no redirect is requested.
- R2: Flag bit 0 belongs to the timer, bit 1 to the port change and bit 2 to the external pin. A flag sets on a falling edge of its input, and a rising edge has no effect.
- R3: The timer and external flags set on their event whatever the mask bits and the global enable are.
- R4: The port-change flag sets on its event only while mask bit 1 is 1.
- R5: With reg_sel = 0, reg_rdata returns flag AND mask. With reg_sel = 1, it returns the mask register.
- R6: A write with reg_sel = 0 clears the flag bits written as 0 and keeps the bits written as 1. An event in the same cycle as such a write leaves its flag set. A write with reg_sel = 1 loads the mask.
- R7: gie_set or reti sets the global enable, and gie_clr clears it. gie_clr wins over gie_set or reti in the same cycle.
- R8: While the global enable is 1 and any flag AND mask bit is 1, redir_valid is 1 with redir_addr = 0x008. The global enable is 0 in the following cycle.
- R9: swi while the global enable is 1 gives redir_valid with redir_addr = 0x001, even over a pending hardware request. swi while the global enable is 0 has no effect.
- R10: A flag that is not cleared is taken again as soon as the global enable is set again.
- R11: While sleep_i is 1, wake is 1 whenever flag bit 1 AND mask bit 1 is 1, whatever the global enable. With the global enable at 1, a redirect is requested as well.
- R12: Events on several sources in the same cycle all set their flags in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_n | input | 1 | Timer overflow request, active on falling edge |
| port_chg_n | input | 1 | Port change request, active on falling edge |
| ext_int_n | input | 1 | External interrupt pin, active on falling edge |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects flags/status, 1 selects mask |
| reg_wdata | input | 3 | Write data |
| reg_rdata | output | 3 | Read data, status or mask |
| gie_set | input | 1 | Enable-interrupts strobe |
| gie_clr | input | 1 | Disable-interrupts strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| swi | input | 1 | Software-trap strobe |
| sleep_i | input | 1 | Core is sleeping |
| gie | output | 1 | Global interrupt enable |
| redir_valid | output | 1 | Fetch redirect request |
| redir_addr | output | PC_W | Redirect target address |
| wake | output | 1 | Wake request for a sleeping core |

## Verification
Several rules are checked on every cycle by assertions. After a redirect, the global enable must be off. After a lone enable or return strobe it must be on, and after a disable strobe it must be off. The port-change flag may rise only if its mask bit was set. The timer event must leave its flag set, and flags may never drop without a flag write. Other behaviour can only be shown by the bench scenarios. These are the masked status value, rising edges being ignored, the event-versus-write race, software-trap priority, re-entry into a flag that was never cleared, and waking with or without vectoring.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_TMR  = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_EXT  = 2;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqv_edge.sv
// Synchroniser followed by a falling-edge detector for one active-low line.
module irqv_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d[0] = pin_n;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irqv_flags.sv
// Flag and mask registers with the masked status read.
module irqv_flags
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            we,
  input  logic            sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] rdata
);
  logic [NSRC-1:0] flag_q, flag_d, mask_q, mask_d, ev_ok;
  logic            flag_wr, mask_wr, flag_en;

  assign flag_wr = we && (reg_sel_e'(sel) == SEL_FLAG);
  assign mask_wr = we && (reg_sel_e'(sel) == SEL_MASK);

  always_comb begin
    ev_ok           = ev;
    ev_ok[SRC_PORT] = ev[SRC_PORT] & mask_q[SRC_PORT];
    flag_d          = flag_q;
    if (flag_wr) flag_d = flag_q & wdata;
    flag_d  = flag_d | ev_ok;
    flag_en = flag_wr | (|ev_ok);
    mask_d  = mask_wr ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign rdata = (reg_sel_e'(sel) == SEL_MASK) ? mask_q : (flag_q & mask_q);

  a_r4_port_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_PORT]) |-> $past(mask_q[SRC_PORT]));
  a_r3_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev[SRC_TMR] |=> flag_q[SRC_TMR]);
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irqv_gie.sv
// Global enable, redirect arbitration and wake request.
module irqv_gie #(
  parameter int PC_W   = 10,
  parameter int HW_VEC = 8,
  parameter int SW_VEC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            reti,
  input  logic            swi,
  input  logic            pending,
  input  logic            port_pending,
  input  logic            sleep_i,
  output logic            gie,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_addr,
  output logic            wake
);
  localparam logic [PC_W-1:0] HW_ADDR = PC_W'(HW_VEC);
  localparam logic [PC_W-1:0] SW_ADDR = PC_W'(SW_VEC);

  logic gie_q, gie_d, gie_en, hw_take, sw_take;

  assign hw_take     = gie_q & pending;
  assign sw_take     = gie_q & swi;
  assign redir_valid = hw_take | sw_take;
  assign redir_addr  = sw_take ? SW_ADDR : HW_ADDR;

  always_comb begin
    gie_en = redir_valid | gie_clr | gie_set | reti;
    if (redir_valid || gie_clr) gie_d = 1'b0;
    else if (gie_set || reti)   gie_d = 1'b1;
    else                        gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_d;
  end

  assign gie  = gie_q;
  assign wake = sleep_i & port_pending;

  a_r8_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !gie_q);
  a_r7_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !redir_valid) |=> gie_q);
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PC_W        = 10,
  parameter int HW_VEC      = 8,
  parameter int SW_VEC      = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tmr_ovf_n,
  input  logic            port_chg_n,
  input  logic            ext_int_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            reti,
  input  logic            swi,
  input  logic            sleep_i,
  output logic            gie,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_addr,
  output logic            wake
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NSRC-1:0] pins_n, ev, flags, mask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pins_n[SRC_TMR]  = tmr_ovf_n;
  assign pins_n[SRC_PORT] = port_chg_n;
  assign pins_n[SRC_EXT]  = ext_int_n;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqv_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_int_n), .pin_n(pins_n[g]), .fall(ev[g])
    );
  end

  irqv_flags u_flags (
    .clk(clk), .rst_n(rst_int_n), .ev(ev), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .flags(flags), .mask(mask), .rdata(reg_rdata)
  );

  irqv_gie #(.PC_W(PC_W), .HW_VEC(HW_VEC), .SW_VEC(SW_VEC)) u_gie (
    .clk(clk), .rst_n(rst_int_n), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .swi(swi), .pending(|(flags & mask)),
    .port_pending(flags[SRC_PORT] & mask[SRC_PORT]), .sleep_i(sleep_i),
    .gie(gie), .redir_valid(redir_valid), .redir_addr(redir_addr), .wake(wake)
  );
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pins_n;
  logic       reg_we, reg_sel, gie_set, gie_clr, reti, swi, sleep_i;
  logic [2:0] reg_wdata, reg_rdata;
  logic       gie, redir_valid, wake;
  logic [9:0] redir_addr;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_n(pins_n[0]), .port_chg_n(pins_n[1]),
    .ext_int_n(pins_n[2]), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .swi(swi), .sleep_i(sleep_i), .gie(gie),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .wake(wake)
  );

  // {mask[2:0], events[2:0]}
  localparam logic [5:0] VEC [0:7] = '{6'b000_111, 6'b111_111, 6'b010_010,
    6'b000_010, 6'b101_011, 6'b011_110, 6'b100_100, 6'b001_101};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [2:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic s, output logic [2:0] d);
    reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic fire(logic [2:0] which);
    @(negedge clk); pins_n = pins_n & ~which;
    repeat (3) @(negedge clk);
  endtask

  task automatic relax();
    @(negedge clk); pins_n = 3'b111;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_set();
    @(negedge clk); gie_set = 1;
    @(negedge clk); gie_set = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] d, exp_f;
    pins_n = 3'b111; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    gie_set = 0; gie_clr = 0; reti = 0; swi = 0; sleep_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1, d); chk("R1 mask", d, 0);
    chk("R1 gie", gie, 0);
    chk("R1 redirect", redir_valid, 0);
    wr(1, 3'b111); rd(0, d); chk("R1 flags", d, 0);

    // R3 R4 R5 R12 vector table
    foreach (VEC[i]) begin
      wr(0, 3'b000);
      wr(1, VEC[i][5:3]);
      fire(VEC[i][2:0]);
      relax();
      exp_f = VEC[i][2:0] & ~(3'b010 & ~VEC[i][5:3]);
      rd(0, d); chk("R5 masked status", d, exp_f & VEC[i][5:3]);
      rd(1, d); chk("R5 mask read", d, VEC[i][5:3]);
      wr(1, 3'b111);
      rd(0, d); chk("R3 R4 R12 flags", d, exp_f);
    end

    // R2 rising edge ignored
    wr(0, 3'b000);
    @(negedge clk); pins_n = 3'b000; repeat (3) @(negedge clk);
    wr(0, 3'b000);
    relax();
    rd(0, d); chk("R2 rising edge", d, 0);

    // R6 write 1 keeps, 0 clears
    fire(3'b101); relax();
    wr(0, 3'b100);
    rd(0, d); chk("R6 write keep", d, 3'b100);

    // R6 event beats a clearing write in the same cycle
    wr(0, 3'b000);
    @(negedge clk); pins_n[0] = 0;
    @(negedge clk);
    @(negedge clk); reg_we = 1; reg_sel = 0; reg_wdata = 3'b000;
    @(negedge clk); reg_we = 0;
    rd(0, d); chk("R6 event wins", d, 3'b001);
    relax(); wr(0, 3'b000);

    // R8 hardware redirect, R10 re-entry
    wr(1, 3'b001);
    pulse_set(); chk("R7 set", gie, 1);
    fire(3'b001);
    chk("R8 redirect", redir_valid, 1);
    chk("R8 vector", redir_addr, 10'h008);
    @(negedge clk);
    chk("R8 gie off", gie, 0);
    chk("R8 one shot", redir_valid, 0);
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    chk("R10 retaken", redir_valid, 1);
    @(negedge clk); chk("R10 gie off", gie, 0);
    relax(); wr(0, 3'b000);

    // R9 software trap
    wr(1, 3'b000);
    pulse_set();
    @(negedge clk); swi = 1;
    #1 chk("R9 trap", redir_valid, 1);
    chk("R9 trap vector", redir_addr, 10'h001);
    @(negedge clk); swi = 0;
    chk("R9 gie off", gie, 0);
    swi = 1;
    #1 chk("R9 ignored", redir_valid, 0);
    @(negedge clk); swi = 0;
    chk("R9 ignored gie", gie, 0);
    wr(1, 3'b001);
    fire(3'b001);
    chk("R8 no gie no redirect", redir_valid, 0);
    pulse_set(); swi = 1;
    #1 chk("R9 priority", redir_addr, 10'h001);
    @(negedge clk); swi = 0;
    relax(); wr(0, 3'b000);

    // R7 precedence
    @(negedge clk); gie_set = 1; gie_clr = 1;
    @(negedge clk); gie_set = 0; gie_clr = 0;
    chk("R7 clr wins", gie, 0);
    pulse_set(); chk("R7 set again", gie, 1);
    @(negedge clk); gie_clr = 1;
    @(negedge clk); gie_clr = 0;
    chk("R7 clr", gie, 0);

    // R11 wake
    wr(1, 3'b010);
    sleep_i = 1;
    fire(3'b010);
    chk("R11 wake", wake, 1);
    chk("R11 resume", redir_valid, 0);
    pulse_set();
    chk("R11 vector", redir_valid, 1);
    chk("R11 vector addr", redir_addr, 10'h008);
    sleep_i = 0;
    #1 chk("R11 awake", wake, 0);
    relax(); wr(0, 3'b000);

    done = 1;
    summary();
    $finish;
  end
endmodule